// File: doc/BRIEF.md
# Module Clock-Gate and Reset Register Block

This block sits on a simple register bus and owns two sets of module-level controls: a vector of clock-enable lines and a vector of active-low reset lines. Software changes these lines by writing 32-bit control words. The upper half of each word names the bits to update, so one bit can be changed without first reading the word back.

Each line has a monitor bit that software can poll. A monitor bit follows its control bit only after a fixed settling delay, in either direction. A driver can therefore write a change, poll until the change is confirmed, and only then go on, for example to release a reset after asserting it. A clock line can be built without a monitor. Its state is then read from its control bit.

Top module: `modclk_rst_ctrl`

## Requirements
- R1: The address map is fixed. Clock control word n is at 0x600+4n and clock monitor word n is at 0x800+4n. Reset control word n is at 0x900+4n and reset monitor word n is at 0xA00+4n. There are CLK_WORDS clock words and RST_WORDS reset words (default 2 each).
- R2: In a control write, bit 16+k of the write data enables an update of bit k, and bit k then takes write-data bit k. Bits whose enable is 0 keep their value.
- R3: `clk_en_o[16*n+k]` equals bit k of clock control word n. A value of 1 runs that module clock.
- R4: `rst_n_o[16*n+k]` equals bit k of reset control word n. A value of 0 holds that module in reset and a value of 1 releases it.
- R5: For each monitored clock line, monitor bit k of word n takes the value of its control bit exactly SETTLE cycles (default 8) after the write edge that changed it. This holds for both rising and falling changes, and the monitor bit does not change earlier.
- R6: A clock line whose bit in CLK_MON_PRESENT is 0 reads 0 in its monitor word. By default the unmonitored line is flat index 15. Its state is read back from its control bit.
- R7: A reset monitor bit reads 1 while its reset is applied. It becomes the inverse of its control bit SETTLE cycles after the write edge that changed that bit.
- R8: After reset of the block, every control bit is 0, so all `clk_en_o` and `rst_n_o` lines are low. Clock monitors read 0 and reset monitors read 1.
- R9: Writes to the monitor banks, to unmapped offsets and to misaligned offsets have no effect. Control words read back with bits 31:16 equal to 0. Unmapped or misaligned offsets read 0.
- R10: If a control bit is changed and then restored before SETTLE cycles have passed, its monitor bit never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data: the enable mask in bits 31:16 and the values in bits 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| clk_en_o | output | CLK_WORDS*16 | Module clock enables, flat index word*16+bit |
| rst_n_o | output | RST_WORDS*16 | Active-low module resets, flat index word*16+bit |

## Verification
The bench measures monitor latency by polling once per cycle after a write, in both directions. A settling counter that is off by one would show up as a poll count of SETTLE-1 or SETTLE+1. It writes a masked word whose unselected bits carry ones and a word with an all-zero mask. A design that ignored the mask would disturb bits that were not selected. It checks the unmonitored line, writes to the monitor banks, and reads of misaligned and out-of-range words, where a loose address decoder would alias onto a real register. It also checks a change that is reverted early: a counter that does not restart would flip the monitor for a change that never lasted.

// File: rtl/modclk_rst_ctrl_pkg.sv
`timescale 1ns/1ps
package modclk_rst_ctrl_pkg;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CTRL_W   = 16;

  localparam logic [ADDR_W-1:0] CLK_CTRL_BASE = 12'h600;
  localparam logic [ADDR_W-1:0] CLK_MON_BASE  = 12'h800;
  localparam logic [ADDR_W-1:0] RST_CTRL_BASE = 12'h900;
  localparam logic [ADDR_W-1:0] RST_MON_BASE  = 12'hA00;

  typedef enum logic [2:0] {
    BANK_NONE,
    BANK_CLK_CTRL,
    BANK_CLK_MON,
    BANK_RST_CTRL,
    BANK_RST_MON
  } bank_e;

endpackage

// File: rtl/modclk_rst_addr_dec.sv
`timescale 1ns/1ps
module modclk_rst_addr_dec
  import modclk_rst_ctrl_pkg::*;
#(
  parameter int unsigned CLK_WORDS = 2,
  parameter int unsigned RST_WORDS = 2,
  parameter int unsigned IDX_W     = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bank_e             bank_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W-3:0] CLK_LIM = (ADDR_W-2)'(CLK_WORDS);
  localparam logic [ADDR_W-3:0] RST_LIM = (ADDR_W-2)'(RST_WORDS);

  logic [ADDR_W-1:0] off_cc;
  logic [ADDR_W-1:0] off_cm;
  logic [ADDR_W-1:0] off_rc;
  logic [ADDR_W-1:0] off_rm;
  logic              hit_cc;
  logic              hit_cm;
  logic              hit_rc;
  logic              hit_rm;

  // Each bank hit needs: at or above its base, word aligned, word index in range.
  always_comb begin
    off_cc = addr_i - CLK_CTRL_BASE;
    off_cm = addr_i - CLK_MON_BASE;
    off_rc = addr_i - RST_CTRL_BASE;
    off_rm = addr_i - RST_MON_BASE;
    hit_cc = (addr_i >= CLK_CTRL_BASE) && (off_cc[1:0] == 2'b00) && (off_cc[ADDR_W-1:2] < CLK_LIM);
    hit_cm = (addr_i >= CLK_MON_BASE)  && (off_cm[1:0] == 2'b00) && (off_cm[ADDR_W-1:2] < CLK_LIM);
    hit_rc = (addr_i >= RST_CTRL_BASE) && (off_rc[1:0] == 2'b00) && (off_rc[ADDR_W-1:2] < RST_LIM);
    hit_rm = (addr_i >= RST_MON_BASE)  && (off_rm[1:0] == 2'b00) && (off_rm[ADDR_W-1:2] < RST_LIM);
  end

  always_comb begin
    bank_o = BANK_NONE;
    idx_o  = '0;
    if (hit_cc) begin
      bank_o = BANK_CLK_CTRL;
      idx_o  = off_cc[IDX_W+1:2];
    end else if (hit_cm) begin
      bank_o = BANK_CLK_MON;
      idx_o  = off_cm[IDX_W+1:2];
    end else if (hit_rc) begin
      bank_o = BANK_RST_CTRL;
      idx_o  = off_rc[IDX_W+1:2];
    end else if (hit_rm) begin
      bank_o = BANK_RST_MON;
      idx_o  = off_rm[IDX_W+1:2];
    end
  end

endmodule

// File: rtl/modclk_rst_ctrl_bank.sv
`timescale 1ns/1ps
module modclk_rst_ctrl_bank
  import modclk_rst_ctrl_pkg::*;
#(
  parameter int unsigned WORDS = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [WORDS*CTRL_W-1:0] bits_o
);

  logic [CTRL_W-1:0] mask;
  logic [CTRL_W-1:0] val;

  assign mask = wdata_i[DATA_W-1:CTRL_W];
  assign val  = wdata_i[CTRL_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              sel;
    logic [CTRL_W-1:0] word_q;
    logic [CTRL_W-1:0] word_d;

    assign sel = wr_i && (idx_i == IDX_W'(w));

    // Merge: selected bits take the new value, the rest hold.
    always_comb begin
      word_d = (word_q & ~mask) | (val & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel) begin
        word_q <= word_d;
      end
    end

    assign bits_o[w*CTRL_W +: CTRL_W] = word_q;
  end

endmodule

// File: rtl/modclk_rst_settle_mon.sv
`timescale 1ns/1ps
module modclk_rst_settle_mon #(
  parameter int unsigned     WIDTH   = 32,
  parameter int unsigned     SETTLE  = 8,
  parameter logic [WIDTH-1:0] PRESENT = '1,
  parameter logic            RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] target_i,
  output logic [WIDTH-1:0] mon_o
);

  localparam int unsigned      CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SETTLE - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (PRESENT[i]) begin : g_mon
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             mon_q;
      logic             mon_d;
      logic             busy;

      assign busy = (target_i[i] != mon_q);

      // Count while the target differs; any agreement restarts the count.
      always_comb begin
        cnt_d = '0;
        mon_d = mon_q;
        if (busy) begin
          if (cnt_q == LAST) begin
            mon_d = target_i[i];
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          mon_q <= RST_VAL;
        end else begin
          cnt_q <= cnt_d;
          mon_q <= mon_d;
        end
      end

      assign mon_o[i] = mon_q;
    end else begin : g_none
      logic unused_tgt;
      assign unused_tgt = target_i[i];
      assign mon_o[i]   = 1'b0;
    end
  end

endmodule

// File: rtl/modclk_rst_ctrl.sv
`timescale 1ns/1ps
module modclk_rst_ctrl
  import modclk_rst_ctrl_pkg::*;
#(
  parameter int unsigned CLK_WORDS = 2,
  parameter int unsigned RST_WORDS = 2,
  parameter int unsigned SETTLE    = 8,
  parameter logic [CLK_WORDS*16-1:0] CLK_MON_PRESENT = ~((CLK_WORDS*16)'(32'h0000_8000))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [11:0]             bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [CLK_WORDS*16-1:0] clk_en_o,
  output logic [RST_WORDS*16-1:0] rst_n_o
);

  localparam int unsigned CLK_BITS  = CLK_WORDS * CTRL_W;
  localparam int unsigned RST_BITS  = RST_WORDS * CTRL_W;
  localparam int unsigned MAX_WORDS = (CLK_WORDS > RST_WORDS) ? CLK_WORDS : RST_WORDS;
  localparam int unsigned IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_sync_q1;
  logic rst_sync_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end

  logic rst_int_n;
  assign rst_int_n = rst_sync_q2;

  bank_e             bank;
  logic [IDX_W-1:0]  idx;
  logic              wr_clk;
  logic              wr_rst;
  logic [CLK_BITS-1:0] clk_ctrl;
  logic [RST_BITS-1:0] rst_ctrl;
  logic [CLK_BITS-1:0] clk_mon;
  logic [RST_BITS-1:0] rst_mon;
  logic [CTRL_W-1:0]   rd_word;

  modclk_rst_addr_dec #(
    .CLK_WORDS (CLK_WORDS),
    .RST_WORDS (RST_WORDS),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr_i (bus_addr),
    .bank_o (bank),
    .idx_o  (idx)
  );

  assign wr_clk = bus_wr && (bank == BANK_CLK_CTRL);
  assign wr_rst = bus_wr && (bank == BANK_RST_CTRL);

  modclk_rst_ctrl_bank #(
    .WORDS (CLK_WORDS),
    .IDX_W (IDX_W)
  ) u_clk_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (wr_clk),
    .idx_i   (idx),
    .wdata_i (bus_wdata),
    .bits_o  (clk_ctrl)
  );

  modclk_rst_ctrl_bank #(
    .WORDS (RST_WORDS),
    .IDX_W (IDX_W)
  ) u_rst_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (wr_rst),
    .idx_i   (idx),
    .wdata_i (bus_wdata),
    .bits_o  (rst_ctrl)
  );

  modclk_rst_settle_mon #(
    .WIDTH   (CLK_BITS),
    .SETTLE  (SETTLE),
    .PRESENT (CLK_MON_PRESENT),
    .RST_VAL (1'b0)
  ) u_clk_mon (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .target_i (clk_ctrl),
    .mon_o    (clk_mon)
  );

  // A reset monitor reads 1 while the reset is applied, so it tracks the inverse.
  modclk_rst_settle_mon #(
    .WIDTH   (RST_BITS),
    .SETTLE  (SETTLE),
    .PRESENT ({RST_BITS{1'b1}}),
    .RST_VAL (1'b1)
  ) u_rst_mon (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .target_i (~rst_ctrl),
    .mon_o    (rst_mon)
  );

  always_comb begin
    rd_word = '0;
    unique case (bank)
      BANK_CLK_CTRL: rd_word = clk_ctrl[int'(idx)*CTRL_W +: CTRL_W];
      BANK_CLK_MON:  rd_word = clk_mon[int'(idx)*CTRL_W +: CTRL_W];
      BANK_RST_CTRL: rd_word = rst_ctrl[int'(idx)*CTRL_W +: CTRL_W];
      BANK_RST_MON:  rd_word = rst_mon[int'(idx)*CTRL_W +: CTRL_W];
      default:       rd_word = '0;
    endcase
  end

  assign bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, rd_word};
  assign clk_en_o  = clk_ctrl;
  assign rst_n_o   = rst_ctrl;

endmodule

// File: rtl/modclk_rst_ctrl_chk.sv
`timescale 1ns/1ps
module modclk_rst_ctrl_chk #(
  parameter int unsigned CLK_BITS = 32,
  parameter int unsigned RST_BITS = 32,
  parameter int unsigned SETTLE   = 8,
  parameter logic [CLK_BITS-1:0] MON_PRESENT = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [11:0]         bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [CLK_BITS-1:0] clk_en,
  input logic [RST_BITS-1:0] rst_lines,
  input logic [CLK_BITS-1:0] clk_mon,
  input logic [RST_BITS-1:0] rst_mon
);

  AST_MASK_KEEPS_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h600) |=>
      (((clk_en[15:0] ^ $past(clk_en[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0)); // R2

  AST_CLK_WRITE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h600) |=>
      (((clk_en[15:0] ^ $past(bus_wdata[15:0])) & $past(bus_wdata[31:16])) == 16'h0)); // R3

  AST_RST_WRITE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h900) |=>
      (((rst_lines[15:0] ^ $past(bus_wdata[15:0])) & $past(bus_wdata[31:16])) == 16'h0)); // R4

  AST_CLK_MON_TAKES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_mon ^ $past(clk_mon)) & (clk_mon ^ $past(clk_en))) == '0); // R5

  AST_CLK_MON_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mon & ~MON_PRESENT) == '0); // R6

  AST_RST_MON_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_mon ^ $past(rst_mon)) & ~(rst_mon ^ $past(rst_lines))) == '0); // R7

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 12'h000) |-> (bus_rdata == 32'h0)); // R9

  if (SETTLE > 1) begin : g_early
    AST_MON_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(clk_en) ^ $past(clk_en, 2)) & (clk_mon ^ $past(clk_mon))) == '0); // R10
  end

endmodule

bind modclk_rst_ctrl modclk_rst_ctrl_chk #(
  .CLK_BITS    (CLK_WORDS*16),
  .RST_BITS    (RST_WORDS*16),
  .SETTLE      (SETTLE),
  .MON_PRESENT (CLK_MON_PRESENT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .clk_en    (clk_en_o),
  .rst_lines (rst_n_o),
  .clk_mon   (clk_mon),
  .rst_mon   (rst_mon)
);

// File: tb/modclk_rst_ctrl_tb.sv
`timescale 1ns/1ps
module modclk_rst_ctrl_tb;

  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] clk_en_o;
  logic [31:0] rst_n_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  modclk_rst_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_en_o  (clk_en_o),
    .rst_n_o   (rst_n_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    bus_addr = a;
    #1;
    q = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles from the write edge until the selected monitor bit reads want.
  task automatic poll(input logic [11:0] a, input int b, input logic want, output int n);
    logic [31:0] q;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(a, q);
      if (q[b] == want) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] q;
    chk("R8", "clk_en_o", clk_en_o, 32'h0);
    chk("R8", "rst_n_o", rst_n_o, 32'h0);
    rd(12'h600, q); chk("R8", "clk ctrl w0", q, 32'h0);
    rd(12'h804, q); chk("R8", "clk mon w1", q, 32'h0);
    rd(12'hA00, q); chk("R8", "rst mon w0", q, 32'h0000_FFFF);
    rd(12'hA04, q); chk("R8", "rst mon w1", q, 32'h0000_FFFF);
  endtask

  task automatic t_masked_write();
    logic [31:0] q;
    wr(12'h600, 32'h00FF_00A5);
    rd(12'h600, q); chk("R2", "low byte select", q, 32'h0000_00A5);
    wr(12'h600, 32'h0F00_FFFF);
    rd(12'h600, q); chk("R2", "nibble select keeps others", q, 32'h0000_0FA5);
    wr(12'h600, 32'h0001_0000);
    rd(12'h600, q); chk("R2", "single bit clear", q, 32'h0000_0FA4);
    wr(12'h600, 32'h0000_FFFF);
    rd(12'h600, q); chk("R2", "empty mask no change", q, 32'h0000_0FA4);
    wr(12'h604, 32'h8000_8000);
    chk("R3", "clk_en_o flat index 31", clk_en_o, 32'h8000_0FA4);
    rd(12'h604, q); chk("R1", "clk ctrl w1 readback", q, 32'h0000_8000);
  endtask

  task automatic t_mon_latency();
    logic [31:0] q;
    idle(2*SETTLE);
    wr(12'h604, 32'h0004_0004);
    idle(SETTLE-1);
    rd(12'h804, q); chk("R5", "rise not early", {31'h0, q[2]}, 32'h0);
    idle(1);
    rd(12'h804, q); chk("R5", "rise at SETTLE", {31'h0, q[2]}, 32'h1);
    wr(12'h604, 32'h0004_0000);
    idle(SETTLE-1);
    rd(12'h804, q); chk("R5", "fall not early", {31'h0, q[2]}, 32'h1);
    idle(1);
    rd(12'h804, q); chk("R5", "fall at SETTLE", {31'h0, q[2]}, 32'h0);
  endtask

  task automatic t_unmonitored();
    logic [31:0] q;
    wr(12'h600, 32'h8000_8000);
    idle(2*SETTLE);
    rd(12'h800, q); chk("R6", "clk mon w0, bit15 absent", q, 32'h0000_0FA4);
    rd(12'h600, q); chk("R6", "bit15 via ctrl", q, 32'h0000_8FA4);
  endtask

  task automatic t_ignored();
    logic [31:0] q;
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'hA04, 32'hFFFF_0000);
    wr(12'h608, 32'hFFFF_FFFF);
    wr(12'h602, 32'hFFFF_0000);
    wr(12'h000, 32'hFFFF_0000);
    idle(2);
    rd(12'h800, q); chk("R9", "clk mon write ignored", q, 32'h0000_0FA4);
    rd(12'hA04, q); chk("R9", "rst mon write ignored", q, 32'h0000_FFFF);
    chk("R9", "stray writes leave clk_en_o", clk_en_o, 32'h8000_8FA4);
    chk("R9", "stray writes leave rst_n_o", rst_n_o, 32'h0);
    rd(12'h608, q); chk("R9", "out of range word", q, 32'h0);
    rd(12'h602, q); chk("R9", "misaligned", q, 32'h0);
    rd(12'hB00, q); chk("R9", "past reset monitors", q, 32'h0);
    rd(12'h000, q); chk("R9", "offset zero", q, 32'h0);
  endtask

  task automatic t_reset_sequence();
    logic [31:0] q;
    int n;
    wr(12'h904, 32'h0020_0020);
    chk("R4", "release drives rst_n_o[21] high", rst_n_o, 32'h0020_0000);
    rd(12'h904, q); chk("R1", "rst ctrl w1 readback", q, 32'h0000_0020);
    poll(12'hA04, 5, 1'b0, n);
    chk("R7", "release confirm cycles", n, SETTLE);
    wr(12'h904, 32'h0020_0000);
    chk("R4", "assert drives rst_n_o[21] low", rst_n_o, 32'h0);
    poll(12'hA04, 5, 1'b1, n);
    chk("R7", "assert confirm cycles", n, SETTLE);
    wr(12'h904, 32'h0020_0020);
    poll(12'hA04, 5, 1'b0, n);
    chk("R7", "re-release after confirmed assert", n, SETTLE);
    rd(12'hA00, q); chk("R7", "word0 still in reset", q, 32'h0000_FFFF);
  endtask

  task automatic t_revert();
    logic [31:0] q;
    int flips = 0;
    wr(12'h604, 32'h0002_0002);
    idle(3);
    wr(12'h604, 32'h0002_0000);
    for (int i = 0; i < 2*SETTLE; i++) begin
      rd(12'h804, q);
      if (q[1]) flips++;
      @(negedge clk);
    end
    chk("R10", "monitor flips after early revert", flips, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_masked_write();
    t_mon_latency();
    t_unmonitored();
    t_ignored();
    t_reset_sequence();
    t_revert();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule